// File: doc/BRIEF.md
# Audio Serial Port Control and Status Register

This block is the control and status register of a stereo serial audio transmit/receive port. A simple 32-bit bus slave writes the control bits and reads back one status word. That word shows the live state of the transmit and receive FIFOs, which channel (left or right) the word-select clock is currently on, and a sticky transmit-underrun flag. Software clears the underrun flag by writing a one to it.

The block also sits between the FIFOs and the DMA engine. Each direction has a request/acknowledge pair. The FIFO logic raises a "need" level when it wants a transfer. The block turns that level into a DMA request unless software has paused that direction. A pause never cuts a transfer short: once a request is raised, it holds until its acknowledge, and the pause applies from the cycle after. A separate control bit drives a pause command for the transmit channel. The underrun flag, gated by its enable bit, drives a level interrupt.

Top module: `aud_serial_csr`

## Requirements
- R1: During and after reset, with both FIFO-empty inputs high and the other status inputs low, the read word is 0x0000_0600, and irq, tx_ch_pause and both DMA requests are 0 while both need inputs are 0.
- R2: Bit 17 is set by a tx_underrun pulse and stays set. A write with bit 17 = 1 clears it. A write with bit 17 = 0 leaves it unchanged.
- R3: When tx_underrun and a write with bit 17 = 1 fall in the same cycle, bit 17 is 1 afterwards.
- R4: irq is 1 exactly when bit 16 (interrupt enable, read/write) and bit 17 are both 1.
- R5: Bit 11 reads chan_right XOR lr_pol. With lr_pol = 0, a value of 0 means left. With lr_pol = 1, a value of 0 means right.
- R6: Bits 10, 9, 8 and 7 read tx_empty, rx_empty, tx_full and rx_full respectively.
- R7: Bits 31:18 and 15:12 always read 0, and writes to them change nothing.
- R8: Once a DMA request is high, it stays high until the cycle in which its acknowledge is high, whatever the pause bit does.
- R9: Bit 6 pauses transmit DMA and bit 5 pauses receive DMA (read/write). With the pause bit set and no transfer under way, the request stays 0 even while need is 1. A pause set during a transfer takes effect on the cycle after the acknowledge.
- R10: After a write clears a pause bit, the request follows need again from the next cycle.
- R11: Bit 4 is read/write and drives tx_ch_pause.
- R12: With no transfer under way and pause clear, the request equals the need input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_wr | input | 1 | Access is a write when high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read word (always valid) |
| tx_empty | input | 1 | Transmit FIFO empty |
| rx_empty | input | 1 | Receive FIFO empty |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| tx_underrun | input | 1 | One-cycle transmit underrun event |
| chan_right | input | 1 | Word-select clock is on the right channel |
| lr_pol | input | 1 | Channel polarity setting from the mode register |
| irq | output | 1 | Underrun interrupt, level |
| tx_need | input | 1 | Transmit FIFO wants a DMA transfer |
| tx_ack | input | 1 | Transmit DMA acknowledge |
| tx_req | output | 1 | Transmit DMA request |
| rx_need | input | 1 | Receive FIFO wants a DMA transfer |
| rx_ack | input | 1 | Receive DMA acknowledge |
| rx_req | output | 1 | Receive DMA request |
| tx_ch_pause | output | 1 | Transmit channel pause command |

## Verification
The DMA assertions assume that an acknowledge arrives only while its request is high and lasts a single cycle. The bench raises each acknowledge for exactly one cycle and only after checking that the request is up. The underrun assertions assume tx_underrun is a single-cycle event, which the bench keeps to. It sweeps every combination of the six status inputs and every combination of existing flag, event and clear write.

// File: rtl/aud_csr_pkg.sv
// Package: bit positions, masks and shared types of the audio serial
// control/status register. Assumes a single 32-bit register word.
package aud_csr_pkg;
    localparam int unsigned CSR_W  = 32;
    localparam int unsigned N_DMA  = 2;
    localparam int unsigned DMA_TX = 0;
    localparam int unsigned DMA_RX = 1;

    localparam int unsigned B_URUN = 17;
    localparam int unsigned B_URIE = 16;
    localparam int unsigned B_LR   = 11;
    localparam int unsigned B_TXE  = 10;
    localparam int unsigned B_RXE  = 9;
    localparam int unsigned B_TXF  = 8;
    localparam int unsigned B_RXF  = 7;
    localparam int unsigned B_TXDP = 6;
    localparam int unsigned B_RXDP = 5;
    localparam int unsigned B_CHP  = 4;

    localparam logic [CSR_W-1:0] RSVD_MASK = 32'hFFFC_F000;

    typedef struct packed {
        logic             urie;
        logic [N_DMA-1:0] dma_pause;
        logic             ch_pause;
    } ctl_t;
endpackage

// File: rtl/aud_urun_flag.sv
// Sticky underrun flag: set by an event pulse, cleared by a write-one.
// Assumes set_evt is a single-cycle pulse; set beats clear.
module aud_urun_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag
);
    // Flag update with set priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (set_evt) flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // R2: flag stays set unless a clear write arrives
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag && !clr_req |=> flag);
    // R3: an event always leaves the flag set
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);
endmodule

// File: rtl/aud_dma_gate.sv
// One DMA request path. Request follows need unless paused; once
// raised it is held until ack, so a pause acts after the transfer.
// Assumes ack is a one-cycle pulse and only while req is high.
module aud_dma_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic need,
    input  logic pause,
    input  logic ack,
    output logic req
);
    logic busy;

    // Track a transfer in progress from request to acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   busy <= 1'b0;
        else if (ack) busy <= 1'b0;
        else if (req) busy <= 1'b1;
    end

    // Request while busy, or when needed and not paused.
    always_comb req = busy | (need & ~pause);

    // R8: request holds until acknowledged
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        req && !ack |=> req);
    // R9: a pause present at acknowledge blocks the following cycle
    a_r9_stop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        req && ack && pause |=> (!req || !pause));
endmodule

// File: rtl/aud_csr_regs.sv
// Control bit storage and read word assembly. Assumes status inputs
// are already synchronous to clk.
module aud_csr_regs
    import aud_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wdata,
    input  logic             tx_empty,
    input  logic             rx_empty,
    input  logic             tx_full,
    input  logic             rx_full,
    input  logic             chan_right,
    input  logic             lr_pol,
    input  logic             urun_flag,
    output ctl_t             ctl,
    output logic [CSR_W-1:0] rdata
);
    logic unused_wbits;
    assign unused_wbits = ^(wdata & RSVD_MASK);

    // Control bits: written as a group, zero at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (wr_en) begin
            ctl.urie              <= wdata[B_URIE];
            ctl.dma_pause[DMA_TX] <= wdata[B_TXDP];
            ctl.dma_pause[DMA_RX] <= wdata[B_RXDP];
            ctl.ch_pause          <= wdata[B_CHP];
        end
    end

    // Read word: live status plus stored control bits.
    always_comb begin
        rdata         = '0;
        rdata[B_URUN] = urun_flag;
        rdata[B_URIE] = ctl.urie;
        rdata[B_LR]   = chan_right ^ lr_pol;
        rdata[B_TXE]  = tx_empty;
        rdata[B_RXE]  = rx_empty;
        rdata[B_TXF]  = tx_full;
        rdata[B_RXF]  = rx_full;
        rdata[B_TXDP] = ctl.dma_pause[DMA_TX];
        rdata[B_RXDP] = ctl.dma_pause[DMA_RX];
        rdata[B_CHP]  = ctl.ch_pause;
    end
endmodule

// File: rtl/aud_serial_csr.sv
// Top: control/status register of a serial audio port with underrun
// interrupt and pausable DMA request paths. Assumes one register word.
module aud_serial_csr
    import aud_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [CSR_W-1:0] bus_wdata,
    output logic [CSR_W-1:0] bus_rdata,
    input  logic             tx_empty,
    input  logic             rx_empty,
    input  logic             tx_full,
    input  logic             rx_full,
    input  logic             tx_underrun,
    input  logic             chan_right,
    input  logic             lr_pol,
    output logic             irq,
    input  logic             tx_need,
    input  logic             tx_ack,
    output logic             tx_req,
    input  logic             rx_need,
    input  logic             rx_ack,
    output logic             rx_req,
    output logic             tx_ch_pause
);
    ctl_t             ctl;
    logic             wr_en;
    logic             urun_flag;
    logic [N_DMA-1:0] need_v, ack_v, req_v;

    // Write strobe decode.
    always_comb wr_en = bus_en & bus_wr;

    aud_csr_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(bus_wdata),
        .tx_empty(tx_empty), .rx_empty(rx_empty), .tx_full(tx_full),
        .rx_full(rx_full), .chan_right(chan_right), .lr_pol(lr_pol),
        .urun_flag(urun_flag), .ctl(ctl), .rdata(bus_rdata)
    );

    aud_urun_flag u_urun (
        .clk(clk), .rst_n(rst_n), .set_evt(tx_underrun),
        .clr_req(wr_en & bus_wdata[B_URUN]), .flag(urun_flag)
    );

    // Pack per-direction DMA signals.
    always_comb begin
        need_v[DMA_TX] = tx_need;
        need_v[DMA_RX] = rx_need;
        ack_v[DMA_TX]  = tx_ack;
        ack_v[DMA_RX]  = rx_ack;
    end

    for (genvar g = 0; g < N_DMA; g++) begin : g_dma
        aud_dma_gate u_gate (
            .clk(clk), .rst_n(rst_n), .need(need_v[g]),
            .pause(ctl.dma_pause[g]), .ack(ack_v[g]), .req(req_v[g])
        );
    end

    // Output drive.
    always_comb begin
        tx_req      = req_v[DMA_TX];
        rx_req      = req_v[DMA_RX];
        irq         = urun_flag & ctl.urie;
        tx_ch_pause = ctl.ch_pause;
    end

    // R4: interrupt only with enable and flag both visible
    a_r4_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (bus_rdata[B_URIE] && bus_rdata[B_URUN]));
    // R7: reserved bits never read nonzero
    a_r7_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & RSVD_MASK) == '0);
    // R11: channel pause output agrees with its read-back bit
    a_r11_ch_pause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ch_pause == bus_rdata[B_CHP]);
endmodule

// File: tb/tb_aud_serial_csr.sv
module tb_aud_serial_csr;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        bus_en = 0, bus_wr = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        tx_empty = 1, rx_empty = 1, tx_full = 0, rx_full = 0;
    logic        tx_underrun = 0, chan_right = 0, lr_pol = 0;
    logic        irq, tx_req, rx_req, tx_ch_pause;
    logic        tx_need = 0, tx_ack = 0, rx_need = 0, rx_ack = 0;
    int          checks = 0, errors = 0;
    logic        done = 0;

    always #10 clk = ~clk;

    aud_serial_csr dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_empty(tx_empty), .rx_empty(rx_empty), .tx_full(tx_full),
        .rx_full(rx_full), .tx_underrun(tx_underrun),
        .chan_right(chan_right), .lr_pol(lr_pol), .irq(irq),
        .tx_need(tx_need), .tx_ack(tx_ack), .tx_req(tx_req),
        .rx_need(rx_need), .rx_ack(rx_ack), .rx_req(rx_req),
        .tx_ch_pause(tx_ch_pause)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Advance past a rising edge; inputs change here, checks 3 ns later.
    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic settle();
        #3;
    endtask

    task automatic wr(logic [31:0] d);
        bus_en = 1; bus_wr = 1; bus_wdata = d;
        step();
        bus_en = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    function automatic logic [31:0] stat_word(logic te, logic re, logic tf,
                                              logic rf, logic cr, logic lp);
        return ({31'b0, cr ^ lp} << 11) | ({31'b0, te} << 10) |
               ({31'b0, re} << 9) | ({31'b0, tf} << 8) | ({31'b0, rf} << 7);
    endfunction

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
    end

    initial begin
        // R1 reset state
        step(); step(); settle();
        chk("R1 rdata in reset", bus_rdata, 32'h0000_0600);
        step(); rst_n = 1; settle();
        chk("R1 rdata", bus_rdata, 32'h0000_0600);
        chk("R1 outs", {28'b0, irq, tx_ch_pause, tx_req, rx_req}, 32'h0);

        // R5 R6 exhaustive status sweep
        for (int i = 0; i < 64; i++) begin
            {tx_empty, rx_empty, tx_full, rx_full, chan_right, lr_pol} = 6'(i);
            settle();
            chk("R5 R6 status", bus_rdata,
                stat_word(tx_empty, rx_empty, tx_full, rx_full, chan_right, lr_pol));
            step();
        end
        {tx_empty, rx_empty, tx_full, rx_full, chan_right, lr_pol} = 6'b110000;

        // R2 R3 flag sweep: prior flag x event x clear write
        for (int i = 0; i < 8; i++) begin
            logic pre, ev, clr;
            {pre, ev, clr} = 3'(i);
            wr(32'h0002_0000);
            if (pre) begin tx_underrun = 1; step(); tx_underrun = 0; end
            settle();
            chk("R2 preset", {31'b0, bus_rdata[17]}, {31'b0, pre});
            tx_underrun = ev;
            wr(clr ? 32'h0002_0000 : 32'h0);
            tx_underrun = 0; settle();
            chk(ev ? "R3 set vs clear" : "R2 w1c", {31'b0, bus_rdata[17]},
                {31'b0, ev | (pre & ~clr)});
        end

        // R4 interrupt gating
        wr(32'h0002_0000);
        tx_underrun = 1; step(); tx_underrun = 0; settle();
        chk("R4 irq no enable", {31'b0, irq}, 32'h0);
        wr(32'h0001_0000); settle();
        chk("R4 irq enabled", {31'b0, irq}, 32'h1);
        wr(32'h0003_0000); settle();
        chk("R4 irq after clear", {31'b0, irq}, 32'h0);
        chk("R4 enable readback", bus_rdata & 32'h0003_0000, 32'h0001_0000);

        // R7 R11 all-ones write
        wr(32'hFFFF_FFFF); settle();
        chk("R7 R11 readback", bus_rdata & ~32'h0000_0F80, 32'h0001_0070);
        chk("R11 ch pause", {31'b0, tx_ch_pause}, 32'h1);
        wr(32'h0); settle();
        chk("R11 ch pause off", {31'b0, tx_ch_pause}, 32'h0);

        // R8 R9 R10 R12 per DMA path
        for (int p = 0; p < 2; p++) begin
            logic [31:0] pbit;
            pbit = (p == 0) ? 32'h40 : 32'h20;
            if (p == 0) tx_need = 0; else rx_need = 0;
            settle();
            chk("R12 idle no need", {31'b0, p == 0 ? tx_req : rx_req}, 32'h0);
            if (p == 0) tx_need = 1; else rx_need = 1;
            settle();
            chk("R12 need gives req", {31'b0, p == 0 ? tx_req : rx_req}, 32'h1);
            step();
            wr(pbit); settle();
            chk("R8 held while paused", {31'b0, p == 0 ? tx_req : rx_req}, 32'h1);
            if (p == 0) tx_ack = 1; else rx_ack = 1;
            settle();
            chk("R8 req in ack cycle", {31'b0, p == 0 ? tx_req : rx_req}, 32'h1);
            step();
            tx_ack = 0; rx_ack = 0; settle();
            chk("R9 stopped after ack", {31'b0, p == 0 ? tx_req : rx_req}, 32'h0);
            step(); step(); settle();
            chk("R9 stays paused", {31'b0, p == 0 ? tx_req : rx_req}, 32'h0);
            chk("R9 other path free", {31'b0, p == 0 ? rx_req : tx_req}, 32'h0);
            wr(32'h0); settle();
            chk("R10 resume", {31'b0, p == 0 ? tx_req : rx_req}, 32'h1);
            if (p == 0) tx_ack = 1; else rx_ack = 1;
            step();
            tx_ack = 0; rx_ack = 0; tx_need = 0; rx_need = 0; settle();
            chk("R12 done no need", {31'b0, p == 0 ? tx_req : rx_req}, 32'h0);
        end
        done = 1;
    end

    initial begin
        wait (done);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule